// File: doc/BRIEF.md
# Registered narrow-to-wide bus exchanger

This block moves data between a 12-bit narrow port and a 24-bit wide side made of two 12-bit halves, called 1B and 2B. It is meant for a fast narrow bus feeding a slower wide one. In the narrow-to-wide direction, the 1B half passes through two register stages and the 2B half through one. Two narrow words written on consecutive clock edges therefore appear together as a single wide word. In the wide-to-narrow direction, each half has its own capture register, and a registered select picks which of the two drives the narrow port.

Each of the four data registers has its own active-low load enable. The per-port output enables are also active low, and they are captured on the clock, so direction changes line up with clock edges. Each bidirectional pin is presented as three signals: data in, data out and drive enable. A pad ring or a tristate wrapper can then be attached outside the block.

Top module: `bus_exchanger`

## Requirements
- R1: While rst_ni is low, all data outputs read zero and all drive-enable vectors read zero (not driving). After reset the registered select points at the 1B capture register.
- R2: When en_a2_ni is low at a rising edge, b2_o shows that edge's a_i from the end of that edge onward.
- R3: The narrow-to-1B path has two stages that share en_a1_ni. A value on a_i reaches b1_o only after two rising edges with en_a1_ni low; after the first such edge, b1_o still shows the older value.
- R4: Any data register whose enable is high at a rising edge keeps its value. This applies to the two 1B stages, the 2B register and both wide-to-narrow capture registers.
- R5: Word X is applied with only en_a1_ni low, then word Y on the next edge with both en_a1_ni and en_a2_ni low. Afterwards b1_o = X and b2_o = Y at the same time.
- R6: en_1a_ni low at an edge captures b1_i, and en_2a_ni low captures b2_i. Each capture register loads independently of the other.
- R7: sel_i is captured at the rising edge. Captured value 1 makes a_o show the 1B capture register, and 0 makes it show the 2B capture register.
- R8: oe_a_ni and oe_b_ni are captured at the rising edge. a_oe_o is all ones exactly when the captured oe_a_ni is 0. b1_oe_o and b2_oe_o are all ones exactly when the captured oe_b_ni is 0. Before the edge, the drive enables keep their old value.
- R9: Captured output enables both 1 give all drive enables 0. Both 0 give all three drive-enable vectors all ones. Only one 0 drives only that side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 12 | Narrow port data in |
| a_o | output | 12 | Narrow port data out |
| a_oe_o | output | 12 | Narrow port drive enable per bit |
| b1_i | input | 12 | 1B half data in |
| b1_o | output | 12 | 1B half data out |
| b1_oe_o | output | 12 | 1B half drive enable per bit |
| b2_i | input | 12 | 2B half data in |
| b2_o | output | 12 | 2B half data out |
| b2_oe_o | output | 12 | 2B half drive enable per bit |
| en_a1_ni | input | 1 | Load enable, narrow-to-1B stages, active low |
| en_a2_ni | input | 1 | Load enable, narrow-to-2B register, active low |
| en_1a_ni | input | 1 | Load enable, 1B capture register, active low |
| en_2a_ni | input | 1 | Load enable, 2B capture register, active low |
| sel_i | input | 1 | Narrow output source: 1 = 1B capture, 0 = 2B capture |
| oe_a_ni | input | 1 | Narrow port output enable, active low, clocked |
| oe_b_ni | input | 1 | Wide side output enable, active low, clocked |

## Verification
The assertions check several behaviours on every cycle. They confirm that the single-stage 2B path and both capture paths load from the ports on the edge where their enable is low. They confirm that b1_o and b2_o hold when their enables are high. They also confirm that every drive-enable vector follows the inverted output enable captured one edge earlier. The two-edge latency of the 1B path, the pairing of consecutive narrow words into one wide word, and independent capture followed by a later select change depend on multi-edge ordering. Only the directed scenarios in the bench show those.

// File: rtl/bx_pkg.sv
package bx_pkg;
  localparam int unsigned BX_DATA_W = 12;

  typedef struct packed {
    logic oe_a_n;
    logic oe_b_n;
    logic sel_1b;
  } bx_ctrl_t;

  localparam bx_ctrl_t BX_CTRL_RST = '{oe_a_n: 1'b1, oe_b_n: 1'b1, sel_1b: 1'b1};
endpackage

// File: rtl/bx_en_reg.sv
module bx_en_reg #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (!en_ni) q_o <= d_i;
  end
endmodule

// File: rtl/bx_narrow_to_wide.sv
module bx_narrow_to_wide #(
  parameter int unsigned W       = 12,
  parameter int unsigned STAGES1 = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_1_ni,
  input  logic         en_2_ni,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] b1_o,
  output logic [W-1:0] b2_o
);
  logic [W-1:0] stg [STAGES1+1];

  assign stg[0] = a_i;

  // 1B pipeline: all stages share one enable and shift together
  for (genvar s = 0; s < STAGES1; s++) begin : g_stage
    bx_en_reg #(.W(W)) u_stg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_ni (en_1_ni),
      .d_i   (stg[s]),
      .q_o   (stg[s+1])
    );
  end

  assign b1_o = stg[STAGES1];

  bx_en_reg #(.W(W)) u_b2 (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_ni (en_2_ni),
    .d_i   (a_i),
    .q_o   (b2_o)
  );
endmodule

// File: rtl/bx_wide_to_narrow.sv
module bx_wide_to_narrow #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_1_ni,
  input  logic         en_2_ni,
  input  logic         sel_1b_q_i,
  input  logic [W-1:0] b1_i,
  input  logic [W-1:0] b2_i,
  output logic [W-1:0] a_o
);
  logic [W-1:0] cap1, cap2;

  bx_en_reg #(.W(W)) u_cap1 (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_ni (en_1_ni),
    .d_i   (b1_i),
    .q_o   (cap1)
  );

  bx_en_reg #(.W(W)) u_cap2 (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_ni (en_2_ni),
    .d_i   (b2_i),
    .q_o   (cap2)
  );

  assign a_o = sel_1b_q_i ? cap1 : cap2;
endmodule

// File: rtl/bx_ctrl.sv
module bx_ctrl
  import bx_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         oe_a_ni,
  input  logic         oe_b_ni,
  input  logic         sel_i,
  output logic         sel_1b_q_o,
  output logic [W-1:0] a_drv_o,
  output logic [W-1:0] b_drv_o
);
  bx_ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= BX_CTRL_RST;
    else         ctrl_q <= '{oe_a_n: oe_a_ni, oe_b_n: oe_b_ni, sel_1b: sel_i};
  end

  assign sel_1b_q_o = ctrl_q.sel_1b;
  assign a_drv_o    = {W{~ctrl_q.oe_a_n}};
  assign b_drv_o    = {W{~ctrl_q.oe_b_n}};
endmodule

// File: rtl/bus_exchanger.sv
module bus_exchanger
  import bx_pkg::*;
#(
  parameter int unsigned DATA_W = BX_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] a_i,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] a_oe_o,
  input  logic [DATA_W-1:0] b1_i,
  output logic [DATA_W-1:0] b1_o,
  output logic [DATA_W-1:0] b1_oe_o,
  input  logic [DATA_W-1:0] b2_i,
  output logic [DATA_W-1:0] b2_o,
  output logic [DATA_W-1:0] b2_oe_o,
  input  logic              en_a1_ni,
  input  logic              en_a2_ni,
  input  logic              en_1a_ni,
  input  logic              en_2a_ni,
  input  logic              sel_i,
  input  logic              oe_a_ni,
  input  logic              oe_b_ni
);
  logic              sel_1b_q;
  logic [DATA_W-1:0] b_drv;

  bx_ctrl #(.W(DATA_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .oe_a_ni   (oe_a_ni),
    .oe_b_ni   (oe_b_ni),
    .sel_i     (sel_i),
    .sel_1b_q_o(sel_1b_q),
    .a_drv_o   (a_oe_o),
    .b_drv_o   (b_drv)
  );

  assign b1_oe_o = b_drv;
  assign b2_oe_o = b_drv;

  bx_narrow_to_wide #(.W(DATA_W), .STAGES1(2)) u_n2w (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_1_ni(en_a1_ni),
    .en_2_ni(en_a2_ni),
    .a_i    (a_i),
    .b1_o   (b1_o),
    .b2_o   (b2_o)
  );

  bx_wide_to_narrow #(.W(DATA_W)) u_w2n (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_1_ni   (en_1a_ni),
    .en_2_ni   (en_2a_ni),
    .sel_1b_q_i(sel_1b_q),
    .b1_i      (b1_i),
    .b2_i      (b2_i),
    .a_o       (a_o)
  );
endmodule

// File: rtl/bus_exchanger_chk.sv
module bus_exchanger_chk #(
  parameter int unsigned DATA_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] a_o,
  input logic [DATA_W-1:0] a_oe_o,
  input logic [DATA_W-1:0] b1_i,
  input logic [DATA_W-1:0] b1_o,
  input logic [DATA_W-1:0] b1_oe_o,
  input logic [DATA_W-1:0] b2_i,
  input logic [DATA_W-1:0] b2_o,
  input logic [DATA_W-1:0] b2_oe_o,
  input logic              en_a1_ni,
  input logic              en_a2_ni,
  input logic              en_1a_ni,
  input logic              en_2a_ni,
  input logic              sel_i,
  input logic              oe_a_ni,
  input logic              oe_b_ni
);
  AST_B2_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_a2_ni |=> b2_o == $past(a_i)); // R2
  AST_B2_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_a2_ni |=> $stable(b2_o)); // R4
  AST_B1_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_a1_ni |=> $stable(b1_o)); // R4
  AST_A_FROM_1B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !en_1a_ni) |=> a_o == $past(b1_i)); // R7
  AST_A_FROM_2B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_i && !en_2a_ni) |=> a_o == $past(b2_i)); // R6
  AST_A_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> a_oe_o == {DATA_W{~$past(oe_a_ni)}}); // R8
  AST_B_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (b1_oe_o == {DATA_W{~$past(oe_b_ni)}}) && (b2_oe_o == b1_oe_o)); // R9
endmodule

bind bus_exchanger bus_exchanger_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/bus_exchanger_tb.sv
module bus_exchanger_tb;
  localparam int unsigned W = 12;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned WATCHDOG = 5000;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a_i = '0, b1_i = '0, b2_i = '0;
  logic [W-1:0] a_o, a_oe_o, b1_o, b1_oe_o, b2_o, b2_oe_o;
  logic en_a1_ni = 1'b1, en_a2_ni = 1'b1, en_1a_ni = 1'b1, en_2a_ni = 1'b1;
  logic sel_i = 1'b1, oe_a_ni = 1'b1, oe_b_ni = 1'b1;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bus_exchanger #(.DATA_W(W)) u_dut (.*);

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    tick();
    chk("R1 a_o", a_o, '0);
    chk("R1 b1_o", b1_o, '0);
    chk("R1 b2_o", b2_o, '0);
    chk("R1 a_oe_o", a_oe_o, '0);
    chk("R1 b1_oe_o", b1_oe_o, '0);
    chk("R1 b2_oe_o", b2_oe_o, '0);
    rst_ni = 1'b1;
    tick();
  endtask

  task automatic t_b1_pipe();
    a_i = 12'h111; en_a1_ni = 1'b0;
    tick();
    chk("R3 first edge", b1_o, 12'h000);
    a_i = 12'h222;
    tick();
    chk("R3 second edge", b1_o, 12'h111);
    en_a1_ni = 1'b1; a_i = 12'h999;
    tick();
    chk("R4 1B hold", b1_o, 12'h111);
  endtask

  task automatic t_b2_load();
    a_i = 12'h5A5; en_a2_ni = 1'b0;
    tick();
    chk("R2 2B load", b2_o, 12'h5A5);
    en_a2_ni = 1'b1; a_i = 12'hFFF;
    tick();
    chk("R4 2B hold", b2_o, 12'h5A5);
  endtask

  task automatic t_wide_word();
    a_i = 12'hABC; en_a1_ni = 1'b0; en_a2_ni = 1'b1;
    tick();
    a_i = 12'h345; en_a2_ni = 1'b0;
    tick();
    en_a1_ni = 1'b1; en_a2_ni = 1'b1; a_i = 12'h000;
    chk("R5 wide low half", b1_o, 12'hABC);
    chk("R5 wide high half", b2_o, 12'h345);
    tick();
    chk("R5 wide held", b1_o, 12'hABC);
  endtask

  task automatic t_capture_sel();
    b1_i = 12'h0F0; b2_i = 12'h707; en_1a_ni = 1'b0; en_2a_ni = 1'b0; sel_i = 1'b1;
    tick();
    chk("R7 sel 1B", a_o, 12'h0F0);
    en_1a_ni = 1'b1; en_2a_ni = 1'b1; b1_i = '0; b2_i = '0; sel_i = 1'b0;
    chk("R7 sel before edge", a_o, 12'h0F0);
    tick();
    chk("R7 sel 2B held", a_o, 12'h707);
    sel_i = 1'b1; en_1a_ni = 1'b0; b1_i = 12'h123; b2_i = 12'hEEE;
    tick();
    chk("R6 1B capture alone", a_o, 12'h123);
    en_1a_ni = 1'b1; sel_i = 1'b0;
    tick();
    chk("R6 2B untouched", a_o, 12'h707);
  endtask

  task automatic t_drive();
    oe_a_ni = 1'b0; oe_b_ni = 1'b1;
    chk("R8 before edge", a_oe_o, '0);
    tick();
    chk("R8 A drive", a_oe_o, '1);
    chk("R8 B idle", b1_oe_o, '0);
    oe_b_ni = 1'b0;
    tick();
    chk("R9 both A", a_oe_o, '1);
    chk("R9 both 1B", b1_oe_o, '1);
    chk("R9 both 2B", b2_oe_o, '1);
    oe_a_ni = 1'b1;
    tick();
    chk("R9 B only A", a_oe_o, '0);
    chk("R9 B only 2B", b2_oe_o, '1);
    oe_b_ni = 1'b1;
    tick();
    chk("R9 none A", a_oe_o, '0);
    chk("R9 none 1B", b1_oe_o, '0);
  endtask

  initial begin
    for (int i = 0; i < WATCHDOG && !done; i++) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    t_reset();
    t_b1_pipe();
    t_b2_load();
    t_wide_word();
    t_capture_sel();
    t_drive();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule